// File: doc/BRIEF.md
# Two-Stage Calendar Tick Divider

This block turns a slow real-time input clock into a once-per-second calendar tick. It uses two dividers in series, both running in the input clock domain. The first stage is a narrow down-counter. It fires an intermediate one-cycle enable every (A+1) input cycles, where A is the first-stage setting. The second stage is a wide down-counter that moves only on that enable. When it is at zero and an enable arrives, it fires the final one-cycle tick and reloads with the second-stage setting S.

The overall period is (A+1)·(S+1) input cycles. With A = 127 and S = 255, a 32.768 kHz input gives exactly 1 Hz. The second-stage count is visible at all times as a subseconds value that counts down.

Each stage takes its setting only when it reloads, so software can change a setting without cutting short a count that is already running. After reset both counters sit at their default reload values, whatever the setting inputs hold at that time.

Top module: `rtc_tick_divider`

## Requirements
- R1: While reset is asserted and right after it is released, `apre_tick` and `spre_tick` are 0 and `subsec` is 255, whatever `async_div` and `sync_div` hold. The first-stage counter starts at 127.
- R2: `apre_tick` is a one-cycle pulse. The first pulse comes in the 128th cycle after reset release, and each later pulse follows the previous one by A+1 cycles.
- R3: `subsec` drops by one on each cycle where `apre_tick` is 1 and `subsec` is nonzero. In every other cycle it holds its value, except on a reload.
- R4: `spre_tick` is 1 exactly in the cycles where `apre_tick` is 1 and `subsec` is 0. In the following cycle `subsec` equals the value of `sync_div` sampled in that cycle.
- R5: A new value on `async_div` or `sync_div` has no effect until that stage's next reload. A count already in progress runs to its end unchanged.
- R6: With `async_div` = 0, `apre_tick` is 1 in every cycle once the first reload has happened.
- R7: With both settings held constant, `spre_tick` repeats every (A+1)·(S+1) cycles. With both settings at 0, it is 1 in every cycle.
- R8: The full 15-bit `sync_div` range is honoured on reload. A setting of 32767 loads 32767 into `subsec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| async_div | input | 7 | First-stage setting A, divides by A+1 |
| sync_div | input | 15 | Second-stage setting S, divides by S+1 |
| apre_tick | output | 1 | First-stage enable pulse |
| spre_tick | output | 1 | Final tick pulse |
| subsec | output | 15 | Current second-stage count |

## Verification
The hardest case to reach is a change of setting while a count is in progress. The test must show that the old value still ends the current period and the new value applies only to the next one. To get there, the bench first sets the first stage to divide by one, so that a full second-stage period lasts 32768 cycles. It then writes a new second-stage setting far into that period and checks that the next final tick still lands at the original cycle. Only after that tick does the new reload appear. The same reload rule is also visible right after reset: the default reload value holds for the first period even when the setting inputs already differ.

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider #(
  parameter int A_W   = 7,
  parameter int S_W   = 15,
  parameter int A_DEF = 127,
  parameter int S_DEF = 255
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] async_div,
  input  logic [S_W-1:0] sync_div,
  output logic           apre_tick,
  output logic           spre_tick,
  output logic [S_W-1:0] subsec
);

  logic [A_W-1:0] acnt;

  assign apre_tick = (acnt == '0);
  assign spre_tick = apre_tick && (subsec == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         acnt <= A_W'(A_DEF);
    else if (apre_tick) acnt <= async_div;
    else                acnt <= acnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         subsec <= S_W'(S_DEF);
    else if (spre_tick) subsec <= sync_div;
    else if (apre_tick) subsec <= subsec - 1'b1;

  // R4
  spre_needs_apre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spre_tick |-> apre_tick);

  // R3
  subsec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apre_tick |=> $stable(subsec));

  // R3
  subsec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apre_tick && subsec != '0) |=> (subsec == $past(subsec) - 1'b1));

  // R4
  subsec_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spre_tick |=> (subsec == $past(sync_div)));

  // R6
  apre_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apre_tick && async_div == '0) |=> apre_tick);

endmodule

// File: tb/rtc_tick_divider_test.sv
module rtc_tick_divider_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  async_div = 7'd127;
  logic [14:0] sync_div = 15'd255;
  logic        apre_tick, spre_tick;
  logic [14:0] subsec;

  int tests = 0, fails = 0;
  int cyc;
  logic run = 0;
  int exp_q[$];
  int front;

  always #4 clk = ~clk;

  rtc_tick_divider uut (
    .clk(clk), .rst_n(rst_n), .async_div(async_div), .sync_div(sync_div),
    .apre_tick(apre_tick), .spre_tick(spre_tick), .subsec(subsec)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: compare spre ticks against the scoreboard queue
  always @(negedge clk) if (run) begin
    if (spre_tick) begin
      if (exp_q.size() == 0) chk("R7 unexpected spre_tick", cyc, -1);
      else begin
        front = exp_q.pop_front();
        chk("R7 spre_tick cycle", cyc, front);
      end
    end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
      front = exp_q.pop_front();
      chk("R7 missing spre_tick", cyc, front);
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic start(input int a, input int s);
    @(negedge clk);
    run = 0;
    rst_n = 0;
    async_div = 7'(a);
    sync_div = 15'(s);
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk("R1 apre_tick in reset", int'(apre_tick), 0);
    chk("R1 subsec in reset", int'(subsec), 255);
    rst_n = 1;
    #1;
    chk("R1 spre_tick after release", int'(spre_tick), 0);
    chk("R1 subsec after release", int'(subsec), 255);
    run = 1;
  endtask

  task automatic finish_phase(input int last);
    wait_cyc(last);
    @(posedge clk);
    run = 0;
    while (exp_q.size() > 0) begin
      front = exp_q.pop_front();
      if (front <= last) chk("R7 spre_tick never seen", -1, front);
    end
  endtask

  initial begin
    int cnt;
    // phase 1: defaults, 1 Hz from 32768 cycles
    start(127, 255);
    exp_q.push_back(32767);
    exp_q.push_back(65535);
    wait_cyc(127);
    chk("R2 first apre_tick", int'(apre_tick), 1);
    chk("R3 subsec before first step", int'(subsec), 255);
    wait_cyc(128);
    chk("R2 apre_tick one cycle", int'(apre_tick), 0);
    chk("R3 subsec after first step", int'(subsec), 254);
    cnt = 0;
    while (cyc < 32767) begin
      @(negedge clk);
      if (apre_tick) cnt++;
    end
    chk("R2 apre_tick count over one second", cnt, 255);
    chk("R4 subsec at zero", int'(subsec), 0);
    wait_cyc(32768);
    chk("R4 subsec reload", int'(subsec), 255);
    finish_phase(65540);

    // phase 2: settings differ from defaults; first period still default
    start(3, 1);
    exp_q.push_back(1147);
    exp_q.push_back(1155);
    exp_q.push_back(1163);
    wait_cyc(130);
    chk("R5 new first-stage setting not yet", int'(apre_tick), 0);
    wait_cyc(131);
    chk("R5 first-stage period after reload", int'(apre_tick), 1);
    finish_phase(1170);

    // phase 3: both settings zero
    start(0, 0);
    for (int t = 382; t <= 400; t++) exp_q.push_back(t);
    wait_cyc(127);
    cnt = 0;
    while (cyc < 381) begin
      @(negedge clk);
      if (apre_tick) cnt++;
    end
    chk("R6 apre_tick every cycle", cnt, 254);
    finish_phase(400);

    // phase 4: full-width second stage, setting change mid-count
    start(0, 32767);
    exp_q.push_back(382);
    exp_q.push_back(33150);
    exp_q.push_back(33156);
    wait_cyc(383);
    chk("R8 full-width reload", int'(subsec), 32767);
    wait_cyc(1000);
    sync_div = 15'd5;
    wait_cyc(1001);
    chk("R5 count unchanged by new setting", int'(subsec), 32767 - 618);
    wait_cyc(33151);
    chk("R5 new setting at next reload", int'(subsec), 5);
    finish_phase(33160);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule